// File: doc/BRIEF.md
# Hashed Page Table Translation Walker

This block turns a 32-bit effective address into a physical address by searching a hashed page table held in memory. The segment number (top address nibble) is used directly as a 24-bit virtual segment identifier, the 16-bit page index is folded with it into a 19-bit hash, and that hash picks a 64-byte group of eight 8-byte entries inside a size-aligned table. The walker reads the entries of the primary group one at a time. If none matches, it complements the hash and searches the secondary group the same way.

A requester presents an address with a valid strobe while the walker signals ready. The table base and the table-size mask (size minus one) are sampled when the request is accepted. The walker issues single 64-bit reads on a synchronous memory port that answers one cycle later, and it ends every lookup with a one-cycle response. A hit returns the real page number joined to the page offset, together with the storage-control bits (WIMG) and the protection bits (PP). A fault is returned when both groups miss.

Top module: `hpt_walker`

## Requirements
- R1: After a synchronous reset, reqReady is 1, rspValid is 0 and memRdEn is 0.
- R2: The page offset is ea[11:0], the page index is ea[27:12], and the segment identifier is ea[31:28] zero-extended to 24 bits. All 24 identifier bits take part in the comparison.
- R3: The primary hash is (identifier XOR page index) truncated to 19 bits. The group address is cfgBase OR ((hash << 6) AND cfgMask), slot i is read at group address + 8*i, and every read address lies inside the table.
- R4: The secondary group uses the bitwise complement of the primary hash, truncated to 19 bits, in the same address formula.
- R5: memRdData[63:32] is the first entry word: valid at 63, identifier at 62:39, hash-select flag at 38, and abbreviated index at 37:32, which must equal page index bits 15:10. memRdData[31:0] holds the real page number at 31:12, WIMG at 6:3 and PP at 1:0. Bits 11:7 and 2 are ignored.
- R6: Slots are searched in the order primary 0..7, then secondary 0..7. The first matching slot ends the search, even when a later slot also matches.
- R7: On a hit, rspValid is high for exactly one cycle with rspHit=1, rspFault=0, rspPa={page number, page offset}, and the entry's WIMG and PP.
- R8: When neither group holds a match, the response has rspFault=1, rspHit=0, and rspPa, rspWimg and rspPp all zero.
- R9: An entry whose hash-select flag differs from the probe (1 in the primary group, 0 in the secondary group) is skipped, as are entries with valid=0.
- R10: At most one read is outstanding, and memRdEn is never high on two consecutive cycles. rspValid is first seen 2*N clock edges after the accepting edge, where N is the number of entries read, so a full miss takes 32 edges.
- R11: reqReady is 1 only while idle. A reqValid seen while busy is ignored and produces no response.
- R12: Reset during a lookup abandons it: no response follows, and the walker is ready in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Lookup request strobe |
| reqEa | input | 32 | Effective address to translate |
| reqReady | output | 1 | Walker idle, request accepted this cycle if reqValid |
| cfgBase | input | 32 | Table base address, aligned to the table size |
| cfgMask | input | 32 | Table size minus one (at least 0xFFFF) |
| memRdEn | output | 1 | Read strobe to table memory |
| memAddr | output | 32 | Byte address of the entry read |
| memRdData | input | 64 | Entry returned one cycle after memRdEn |
| rspValid | output | 1 | One-cycle response strobe |
| rspHit | output | 1 | Translation found |
| rspFault | output | 1 | No entry in either group |
| rspPa | output | 32 | Physical address (zero on fault) |
| rspWimg | output | 4 | Storage-control bits of the hit entry |
| rspPp | output | 2 | Protection bits of the hit entry |

## Verification
The bench builds the walker with its default parameters: 4 KiB pages, 256 MiB segments, a 19-bit hash and eight-slot groups. It changes the table size at run time between 64 KiB and 256 KiB, so the higher hash bits reach the group address only in the second case. With a sparse memory model, the bench places decoy entries in chosen slots of both groups. This covers skip on wrong flag, wrong identifier, wrong abbreviated index and cleared valid bit, as well as primary-over-secondary priority and the full 16-read miss. The latency of each response is measured to confirm how many entries were read.

// File: rtl/hptw_pkg.sv
package hptw_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE,
    WALK_READ,
    WALK_CHECK,
    WALK_REPLY
  } walk_state_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic load;
    logic readEn;
    logic nextSlot;
    logic toSecondary;
    logic captureHit;
    logic captureFault;
  } walk_strobe_t;

endpackage

// File: rtl/hptw_ctrl.sv
module hptw_ctrl
  import hptw_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         entryMatch,
  input  logic         lastSlot,
  input  logic         onSecondary,
  output walk_strobe_t strobe,
  output logic         reqReady,
  output logic         rspValid
);

  localparam int MAX_WALK = 4 * SLOTS + 1;
  localparam int CNT_W    = $clog2(MAX_WALK + 1) + 1;

  walk_state_t stateQ, stateD;

  always_comb begin
    stateD   = stateQ;
    strobe   = '0;
    reqReady = 1'b0;
    rspValid = 1'b0;
    unique case (stateQ)
      WALK_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = WALK_READ;
        end
      end
      WALK_READ: begin
        strobe.readEn = 1'b1;
        stateD        = WALK_CHECK;
      end
      WALK_CHECK: begin
        if (entryMatch) begin
          strobe.captureHit = 1'b1;
          stateD            = WALK_REPLY;
        end else if (lastSlot && onSecondary) begin
          strobe.captureFault = 1'b1;
          stateD              = WALK_REPLY;
        end else if (lastSlot) begin
          strobe.toSecondary = 1'b1;
          stateD             = WALK_READ;
        end else begin
          strobe.nextSlot = 1'b1;
          stateD          = WALK_READ;
        end
      end
      WALK_REPLY: begin
        rspValid = 1'b1;
        stateD   = WALK_IDLE;
      end
      default: stateD = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= WALK_IDLE;
    else     stateQ <= stateD;
  end

  // walk length monitor
  logic [CNT_W-1:0] walkCycles;
  always_ff @(posedge clk) begin
    if (rst || stateQ == WALK_IDLE) walkCycles <= '0;
    else                            walkCycles <= walkCycles + 1'b1;
  end

  // R11
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> !reqReady);

  // R10
  single_read_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.readEn |=> !strobe.readEn);

  // R10
  walk_bound_chk: assert property (@(posedge clk) disable iff (rst)
    walkCycles <= CNT_W'(MAX_WALK));

  // R7
  reply_single_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |=> (!rspValid && reqReady));

  // R12
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reqReady && !rspValid && !strobe.readEn));

endmodule

// File: rtl/hptw_datapath.sv
module hptw_datapath
  import hptw_pkg::*;
#(
  parameter int EA_W    = 32,
  parameter int PAGE_LD = 12,
  parameter int SEG_LD  = 28,
  parameter int HASH_W  = 19,
  parameter int GROUP_LD = 6,
  parameter int PTE_LD  = 3,
  parameter int VSID_W  = 24,
  parameter int API_W   = 6,
  parameter int WIMG_W  = 4,
  parameter int PP_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  walk_strobe_t        strobe,
  input  logic [EA_W-1:0]     reqEa,
  input  logic [EA_W-1:0]     cfgBase,
  input  logic [EA_W-1:0]     cfgMask,
  output logic                memRdEn,
  output logic [EA_W-1:0]     memAddr,
  input  logic [2*EA_W-1:0]   memRdData,
  output logic                entryMatch,
  output logic                lastSlot,
  output logic                onSecondary,
  output logic                hitQ,
  output logic                faultQ,
  output logic [EA_W-1:0]     paQ,
  output logic [WIMG_W-1:0]   wimgQ,
  output logic [PP_W-1:0]     ppQ
);

  localparam int PI_W    = SEG_LD - PAGE_LD;
  localparam int ESID_W  = EA_W - SEG_LD;
  localparam int SLOT_W  = GROUP_LD - PTE_LD;
  localparam int SLOTS   = 1 << SLOT_W;
  localparam int RPN_W   = EA_W - PAGE_LD;
  // first word field positions
  localparam int H_POS    = API_W;
  localparam int VSID_LO  = API_W + 1;
  localparam int V_POS    = VSID_LO + VSID_W;
  // second word field positions
  localparam int WIMG_LO  = PP_W + 1;

  logic [EA_W-1:0]   eaQ, baseQ, maskQ;
  logic [SLOT_W-1:0] slotQ;
  logic              secQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      eaQ   <= '0;
      baseQ <= '0;
      maskQ <= '0;
      slotQ <= '0;
      secQ  <= 1'b0;
    end else if (strobe.load) begin
      eaQ   <= reqEa;
      baseQ <= cfgBase;
      maskQ <= cfgMask;
      slotQ <= '0;
      secQ  <= 1'b0;
    end else if (strobe.toSecondary) begin
      secQ  <= 1'b1;
      slotQ <= '0;
    end else if (strobe.nextSlot) begin
      slotQ <= slotQ + 1'b1;
    end
  end

  // address split and hashing
  logic [VSID_W-1:0] vsid;
  logic [PI_W-1:0]   pageIdx;
  logic [API_W-1:0]  apiCalc;
  logic [HASH_W-1:0] hashPri, hashSel;
  logic [EA_W-1:0]   groupOff;

  assign vsid    = VSID_W'(eaQ[EA_W-1 -: ESID_W]);
  assign pageIdx = eaQ[SEG_LD-1:PAGE_LD];
  assign apiCalc = pageIdx[PI_W-1 -: API_W];
  assign hashPri = vsid[HASH_W-1:0] ^ HASH_W'(pageIdx);
  assign hashSel = secQ ? ~hashPri : hashPri;
  assign groupOff = (EA_W'(hashSel) << GROUP_LD) & maskQ;

  assign memRdEn = strobe.readEn;
  assign memAddr = baseQ | groupOff | (EA_W'(slotQ) << PTE_LD);

  // entry decode
  logic [EA_W-1:0]   wordTag, wordMap;
  logic              entValid, entH;
  logic [VSID_W-1:0] entVsid;
  logic [API_W-1:0]  entApi;

  assign wordTag  = memRdData[2*EA_W-1:EA_W];
  assign wordMap  = memRdData[EA_W-1:0];
  assign entValid = wordTag[V_POS];
  assign entVsid  = wordTag[VSID_LO +: VSID_W];
  assign entH     = wordTag[H_POS];
  assign entApi   = wordTag[API_W-1:0];

  assign entryMatch  = entValid && (entVsid == vsid) && (entH == secQ) && (entApi == apiCalc);
  assign lastSlot    = (slotQ == SLOT_W'(SLOTS - 1));
  assign onSecondary = secQ;

  logic unusedBits;
  assign unusedBits = ^{wordMap[PAGE_LD-1:WIMG_LO+WIMG_W], wordMap[PP_W]};

  always_ff @(posedge clk) begin
    if (rst || strobe.captureFault) begin
      hitQ   <= 1'b0;
      faultQ <= !rst;
      paQ    <= '0;
      wimgQ  <= '0;
      ppQ    <= '0;
    end else if (strobe.captureHit) begin
      hitQ   <= 1'b1;
      faultQ <= 1'b0;
      paQ    <= {wordMap[EA_W-1 -: RPN_W], eaQ[PAGE_LD-1:0]};
      wimgQ  <= wordMap[WIMG_LO +: WIMG_W];
      ppQ    <= wordMap[PP_W-1:0];
    end
  end

  // R3
  table_contain_chk: assert property (@(posedge clk) disable iff (rst)
    memRdEn |-> (((memAddr & ~maskQ) == (baseQ & ~maskQ)) && (memAddr[PTE_LD-1:0] == '0)));

  // R8
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    faultQ |-> (!hitQ && paQ == '0 && wimgQ == '0 && ppQ == '0));

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hptw_pkg::*;
#(
  parameter int EA_W     = 32,
  parameter int PAGE_LD  = 12,
  parameter int SEG_LD   = 28,
  parameter int HASH_W   = 19,
  parameter int GROUP_LD = 6,
  parameter int PTE_LD   = 3,
  parameter int VSID_W   = 24,
  parameter int API_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [EA_W-1:0]   reqEa,
  output logic              reqReady,
  input  logic [EA_W-1:0]   cfgBase,
  input  logic [EA_W-1:0]   cfgMask,
  output logic              memRdEn,
  output logic [EA_W-1:0]   memAddr,
  input  logic [2*EA_W-1:0] memRdData,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspFault,
  output logic [EA_W-1:0]   rspPa,
  output logic [3:0]        rspWimg,
  output logic [1:0]        rspPp
);

  localparam int SLOTS = 1 << (GROUP_LD - PTE_LD);

  walk_strobe_t strobe;
  logic entryMatch, lastSlot, onSecondary, hitQ, faultQ;

  hptw_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .entryMatch(entryMatch), .lastSlot(lastSlot), .onSecondary(onSecondary),
    .strobe(strobe), .reqReady(reqReady), .rspValid(rspValid)
  );

  hptw_datapath #(
    .EA_W(EA_W), .PAGE_LD(PAGE_LD), .SEG_LD(SEG_LD), .HASH_W(HASH_W),
    .GROUP_LD(GROUP_LD), .PTE_LD(PTE_LD), .VSID_W(VSID_W), .API_W(API_W),
    .WIMG_W(4), .PP_W(2)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqEa(reqEa),
    .cfgBase(cfgBase), .cfgMask(cfgMask),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .entryMatch(entryMatch), .lastSlot(lastSlot), .onSecondary(onSecondary),
    .hitQ(hitQ), .faultQ(faultQ), .paQ(rspPa), .wimgQ(rspWimg), .ppQ(rspPp)
  );

  assign rspHit   = rspValid && hitQ;
  assign rspFault = rspValid && faultQ;

  // R7
  hit_xor_fault_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspHit != rspFault));

endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0;
  logic [31:0] reqEa = '0;
  logic        reqReady;
  logic [31:0] cfgBase = 32'h0010_0000;
  logic [31:0] cfgMask = 32'h0000_FFFF;
  logic        memRdEn;
  logic [31:0] memAddr;
  logic [63:0] memRdData = '0;
  logic        rspValid, rspHit, rspFault;
  logic [31:0] rspPa;
  logic [3:0]  rspWimg;
  logic [1:0]  rspPp;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpt_walker u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqEa(reqEa), .reqReady(reqReady),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .rspValid(rspValid), .rspHit(rspHit), .rspFault(rspFault),
    .rspPa(rspPa), .rspWimg(rspWimg), .rspPp(rspPp)
  );

  // sparse table memory, one-cycle read latency
  logic [63:0] mem [int unsigned];
  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem.exists(memAddr) ? mem[memAddr] : 64'h0;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard
  typedef struct {
    logic        hit;
    logic [31:0] pa;
    logic [3:0]  wimg;
    logic [1:0]  pp;
    int          lat;
    int          acc;
  } exp_t;
  exp_t  sb[$];
  string tagQ[$];
  int    pending = 0;

  always @(negedge clk) begin
    if (!rst && rspValid) begin
      if (pending == 0) begin
        chk(1'b0, "R11", "unexpected response", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = sb.pop_front();
        t = tagQ.pop_front();
        chk(rspHit == e.hit, t, "hit", {31'b0, rspHit}, {31'b0, e.hit});
        chk(rspFault == !e.hit, t, "fault", {31'b0, rspFault}, {31'b0, !e.hit});
        chk(rspPa == e.pa, t, "pa", rspPa, e.pa);
        chk(rspWimg == e.wimg && rspPp == e.pp, t, "wimg/pp",
            {26'b0, rspWimg, rspPp}, {26'b0, e.wimg, e.pp});
        chk(cyc - e.acc == e.lat, {t, " R10"}, "latency", cyc - e.acc, e.lat);
        pending--;
      end
    end
  end

  // reference model of the address formation
  function automatic logic [31:0] groupAddr(input logic [31:0] ea, input bit sec,
                                            input logic [31:0] base, input logic [31:0] mask);
    logic [18:0] h;
    h = {15'b0, ea[31:28]} ^ {3'b0, ea[27:12]};
    if (sec) h = ~h;
    return base | ({7'b0, h, 6'b0} & mask);
  endfunction

  function automatic logic [31:0] slotAddr(input logic [31:0] ea, input bit sec, input int slot);
    return groupAddr(ea, sec, cfgBase, cfgMask) + 32'(slot * 8);
  endfunction

  function automatic logic [63:0] mkEntry(input bit v, input logic [23:0] vsid, input bit h,
                                          input logic [5:0] api, input logic [19:0] rpn,
                                          input logic [3:0] wimg, input logic [1:0] pp);
    // ignored bits 11:7 and 2 of word 1 set to ones
    return {v, vsid, h, api, rpn, 5'b11111, wimg, 1'b1, pp};
  endfunction

  function automatic logic [23:0] vsidOf(input logic [31:0] ea);
    return {20'b0, ea[31:28]};
  endfunction

  function automatic logic [5:0] apiOf(input logic [31:0] ea);
    return ea[27:22];
  endfunction

  task automatic putGood(input logic [31:0] ea, input bit sec, input int slot,
                         input logic [19:0] rpn, input logic [3:0] wimg, input logic [1:0] pp);
    mem[slotAddr(ea, sec, slot)] = mkEntry(1'b1, vsidOf(ea), sec, apiOf(ea), rpn, wimg, pp);
  endtask

  // a decoy that differs from a match in one field, chosen by kind
  task automatic putDecoy(input logic [31:0] ea, input bit sec, input int slot, input int kind);
    logic [63:0] e;
    case (kind % 4)
      0: e = mkEntry(1'b1, vsidOf(ea) ^ 24'h800000, sec, apiOf(ea), 20'hDEAD1, 4'hF, 2'h3);
      1: e = mkEntry(1'b1, vsidOf(ea), !sec, apiOf(ea), 20'hDEAD2, 4'hF, 2'h3);
      2: e = mkEntry(1'b0, vsidOf(ea), sec, apiOf(ea), 20'hDEAD3, 4'hF, 2'h3);
      default: e = mkEntry(1'b1, vsidOf(ea), sec, apiOf(ea) ^ 6'h01, 20'hDEAD4, 4'hF, 2'h3);
    endcase
    mem[slotAddr(ea, sec, slot)] = e;
  endtask

  task automatic lookup(input logic [31:0] ea, input bit hit, input logic [31:0] pa,
                        input logic [3:0] wimg, input logic [1:0] pp, input int lat,
                        input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1;
    reqEa    = ea;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    e.hit = hit; e.pa = pa; e.wimg = wimg; e.pp = pp; e.lat = lat; e.acc = cyc;
    sb.push_back(e);
    tagQ.push_back(tag);
    pending++;
  endtask

  task automatic waitDone(input string tag);
    wait (pending == 0);
    @(negedge clk);
    chk(rspValid == 1'b0, {tag, " R7"}, "rspValid one cycle", {31'b0, rspValid}, 32'd0);
    chk(reqReady == 1'b1, {tag, " R11"}, "ready after reply", {31'b0, reqReady}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(reqReady == 1'b1, "R1", "ready", {31'b0, reqReady}, 32'd1);
    chk(rspValid == 1'b0, "R1", "rspValid", {31'b0, rspValid}, 32'd0);
    chk(memRdEn == 1'b0, "R1", "memRdEn", {31'b0, memRdEn}, 32'd0);

    // R7 R3 R5: primary slot 0 hit, offset carried through
    mem.delete();
    putGood(32'h3123_4567, 1'b0, 0, 20'hABCDE, 4'h5, 2'h2);
    lookup(32'h3123_4567, 1'b1, 32'hABCD_E567, 4'h5, 2'h2, 2, "R7 primary slot0");
    waitDone("R7");

    // R9 R2 R5: decoys in slots 0..4, match at slot 5
    mem.delete();
    for (int s = 0; s < 5; s++) putDecoy(32'h5ABC_D123, 1'b0, s, s);
    putGood(32'h5ABC_D123, 1'b0, 5, 20'h12345, 4'hA, 2'h1);
    lookup(32'h5ABC_D123, 1'b1, 32'h1234_5123, 4'hA, 2'h1, 12, "R9 decoys then slot5");
    waitDone("R9");

    // R4: primary full of decoys, hit at secondary slot 3
    mem.delete();
    for (int s = 0; s < 8; s++) putDecoy(32'h9876_5FFF, 1'b0, s, s);
    putGood(32'h9876_5FFF, 1'b1, 3, 20'h0F0F0, 4'h3, 2'h0);
    lookup(32'h9876_5FFF, 1'b1, 32'h0F0F_0FFF, 4'h3, 2'h0, 24, "R4 secondary slot3");
    waitDone("R4");

    // R6: matches in primary slot 6 and secondary slot 0, primary wins
    mem.delete();
    putGood(32'h0000_1000, 1'b0, 6, 20'h11111, 4'h1, 2'h1);
    putGood(32'h0000_1000, 1'b1, 0, 20'h22222, 4'h2, 2'h2);
    lookup(32'h0000_1000, 1'b1, 32'h1111_1000, 4'h1, 2'h1, 14, "R6 primary priority");
    waitDone("R6");

    // R8: all 16 slots hold decoys -> fault after 16 reads
    mem.delete();
    for (int s = 0; s < 8; s++) begin
      putDecoy(32'hF00B_A987, 1'b0, s, s + 1);
      putDecoy(32'hF00B_A987, 1'b1, s, s);
    end
    lookup(32'hF00B_A987, 1'b0, 32'h0, 4'h0, 2'h0, 32, "R8 full miss");
    waitDone("R8");

    // R8: empty table
    mem.delete();
    lookup(32'h4444_4444, 1'b0, 32'h0, 4'h0, 2'h0, 32, "R8 empty table");
    waitDone("R8b");

    // R3 R4: larger table, upper hash bits reach the address
    cfgBase = 32'h0040_0000;
    cfgMask = 32'h0003_FFFF;
    mem.delete();
    putGood(32'hE765_4321, 1'b1, 7, 20'hCAFE0, 4'h9, 2'h3);
    lookup(32'hE765_4321, 1'b1, 32'hCAFE_0321, 4'h9, 2'h3, 32, "R3 256K table secondary slot7");
    waitDone("R3");

    // R11: request while busy is ignored
    mem.delete();
    putGood(32'h2222_3333, 1'b1, 3, 20'h54321, 4'h6, 2'h1);
    putGood(32'h7777_8888, 1'b0, 0, 20'h99999, 4'h7, 2'h2);
    lookup(32'h2222_3333, 1'b1, 32'h5432_1333, 4'h6, 2'h1, 24, "R11 first request");
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b0, "R11", "ready while busy", {31'b0, reqReady}, 32'd0);
    reqValid = 1'b1;
    reqEa    = 32'h7777_8888;
    @(negedge clk);
    reqValid = 1'b0;
    waitDone("R11");
    repeat (40) @(negedge clk);
    chk(pending == 0, "R11", "no extra response", pending, 0);

    // R12: reset mid-walk abandons lookup
    mem.delete();
    @(negedge clk);
    reqValid = 1'b1;
    reqEa    = 32'h1357_9BDF;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(reqReady == 1'b1, "R12", "ready after abort", {31'b0, reqReady}, 32'd1);
    chk(memRdEn == 1'b0, "R12", "no read after abort", {31'b0, memRdEn}, 32'd0);
    repeat (40) @(negedge clk);
    chk(pending == 0, "R12", "no response after abort", pending, 0);

    // R12: walker works after the abort
    putGood(32'h1357_9BDF, 1'b0, 2, 20'h0ACE1, 4'hC, 2'h0);
    lookup(32'h1357_9BDF, 1'b1, 32'h0ACE_1BDF, 4'hC, 2'h0, 6, "R12 lookup after abort");
    waitDone("R12");

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule